// File: doc/BRIEF.md
# External Bus Strobe Generator

This block generates the address-latch strobe (ALE, active high) and the program-store read strobe (active low) for an 8-bit microcontroller's external memory bus. A machine cycle lasts 12 clock periods. A phase counter steps through the cycle. Each cycle has attributes: external code fetch, external data access, and wide (16-bit) pointer. These attributes are sampled once at the cycle boundary and held for the whole cycle, so the strobes never change shape in the middle of a cycle.

There are two kinds of suppression:
- **Data-access cycles.** The second ALE pulse and both program-store pulses are dropped.
- **Noise-reduction bit.** A software-written bit keeps ALE parked high during code-fetch cycles. This cuts radiated emissions on systems that run only from internal code.

The block also:
- tells the high-address port whether to drive the high address byte or its own latch contents;
- forces fixed strobe levels in the idle and power-down states.

Top module: `ext_bus_strobe`

## Requirements
- R1: While rst_ni is low, ale_o is 1, psen_no is 1 and hi_addr_sel_o is 0. The noise-reduction bit is cleared. The next machine cycle starts at phase 0 with all cycle attributes clear.
- R2: In a cycle with no data access and the noise-reduction bit clear, ale_o is 1 in phases 0, 1, 6 and 7 and 0 in the other phases. The 12 phases advance one per clock.
- R3: In a data-access cycle, ale_o is 1 only in phases 0 and 1. The pulse at phases 6–7 is omitted.
- R4: In a cycle with the external-fetch attribute and no data access, psen_no is 0 in phases 3–5 and 9–11 and 1 elsewhere. An internal-fetch cycle keeps psen_no at 1.
- R5: In a data-access cycle, psen_no stays 1 for all 12 phases, whatever the fetch attribute is.
- R6: Cycle attributes (ext_fetch_i, data_acc_i, wide_ptr_i) are sampled at the clock edge that ends phase 11. Input changes inside a cycle affect only the following cycle.
- R7: hi_addr_sel_o (1 = high address byte, 0 = port latch) follows the wide-pointer attribute in a data-access cycle. In any other cycle it follows the external-fetch attribute.
- R8: A write with cfg_we_i=1 and cfg_addr_i=0x8E loads bit 0 of cfg_wdata_i into the noise-reduction bit from the next clock onward. While the bit is 1:
  - ale_o is held at 1 in every cycle that is not a data access;
  - data-access cycles keep the R3 pattern;
  - psen_no is unaffected.
- R9: Writes to any other address leave the noise-reduction bit unchanged. Bits 7:1 of the written data are ignored.
- R10: The noise-reduction bit keeps its value until it is rewritten or reset.
- R11: While idle_i=1 (and pdown_i=0), ale_o=1, psen_no=1 and hi_addr_sel_o=0. In this state:
  - the phase is held at 0;
  - the attributes are resampled on every clock;
  - after release, a full cycle starts at phase 0.
- R12: While pdown_i=1, ale_o=0, psen_no=0 and hi_addr_sel_o=0. pdown_i takes priority over idle_i.
- R13: ALE is low in the clock before psen_no falls, and each ALE pulse lasts at least 2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_fetch_i | input | 1 | Next cycle fetches code from external memory |
| data_acc_i | input | 1 | Next cycle accesses external data memory |
| wide_ptr_i | input | 1 | Data access uses a 16-bit pointer |
| idle_i | input | 1 | Idle state request |
| pdown_i | input | 1 | Power-down state request |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_addr_i | input | 8 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| ale_o | output | 1 | Address latch enable |
| psen_no | output | 1 | Program store enable, active low |
| hi_addr_sel_o | output | 1 | High port source: 1 address byte, 0 port latch |

## Verification
A phase counter that slips or wraps at the wrong count shows up at once as ALE and PSEN edges in the wrong clock. Every later cycle is then shifted as well, so the first miscompare appears within one 12-clock machine cycle. A cycle attribute that is latched at the wrong moment shows up in the cycle after the input changed, as a pulse that is missing or extra.

A noise-reduction bit that is lost or wrongly set is seen in the next cycle that is not a data access: ALE is either parked high or pulsing when it should not be. Faults in the low-power forcing appear in the same clock as idle_i or pdown_i. A phase that is not held during low power appears as a shortened first cycle after release.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef struct packed {
    logic ext_fetch;
    logic data_acc;
    logic wide_ptr;
  } cyc_attr_t;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_IDLE = 2'd1,
    PWR_DOWN = 2'd2
  } pwr_mode_t;

endpackage

// File: rtl/ebs_phase_seq.sv
module ebs_phase_seq
  import ebs_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int PH_W    = $clog2(CYC_LEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  cyc_attr_t       attr_i,
  output logic [PH_W-1:0] phase_o,
  output cyc_attr_t       attr_o
);

  localparam logic [PH_W-1:0] LAST = PH_W'(CYC_LEN - 1);

  logic [PH_W-1:0] phase_q;
  cyc_attr_t       attr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      attr_q  <= '0;
    end else if (hold_i) begin
      // low power: park at cycle start, track attributes for the restart
      phase_q <= '0;
      attr_q  <= attr_i;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
      attr_q  <= attr_i;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign attr_o  = attr_q;

endmodule

// File: rtl/ebs_rfi_reg.sv
module ebs_rfi_reg #(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] RFI_ADDR = 8'h8E,
  parameter int                RFI_BIT  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rfi_o
);

  logic hit;
  logic rfi_q;

  assign hit = we_i && (addr_i == RFI_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rfi_q <= 1'b0;
    else if (hit) rfi_q <= wdata_i[RFI_BIT];
  end

  assign rfi_o = rfi_q;

endmodule

// File: rtl/ebs_strobe_decode.sv
module ebs_strobe_decode
  import ebs_pkg::*;
#(
  parameter int CYC_LEN    = 12,
  parameter int PH_W       = $clog2(CYC_LEN),
  parameter int ALE_WIDTH  = 2,
  parameter int PSEN_START = 3
) (
  input  logic [PH_W-1:0] phase_i,
  input  cyc_attr_t       attr_i,
  input  logic            rfi_i,
  input  pwr_mode_t       mode_i,
  output logic            ale_o,
  output logic            psen_no,
  output logic            hi_sel_o
);

  localparam int HALVES = 2;
  localparam int HALF   = CYC_LEN / HALVES;

  logic [HALVES-1:0] ale_win;
  logic [HALVES-1:0] psen_win;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    localparam logic [PH_W-1:0] H_LO  = PH_W'(h * HALF);
    localparam logic [PH_W-1:0] H_ALE = PH_W'(h * HALF + ALE_WIDTH);
    localparam logic [PH_W-1:0] H_PS  = PH_W'(h * HALF + PSEN_START);
    localparam logic [PH_W-1:0] H_END = PH_W'((h + 1) * HALF);
    assign ale_win[h]  = (phase_i >= H_LO) && (phase_i < H_ALE);
    assign psen_win[h] = (phase_i >= H_PS) && (phase_i < H_END);
  end

  always_comb begin
    ale_o    = 1'b1;
    psen_no  = 1'b1;
    hi_sel_o = 1'b0;
    unique case (mode_i)
      PWR_DOWN: begin
        ale_o   = 1'b0;
        psen_no = 1'b0;
      end
      PWR_IDLE: begin
        ale_o   = 1'b1;
        psen_no = 1'b1;
      end
      default: begin
        if (attr_i.data_acc) begin
          // data cycle: only the address pulse of the first half survives
          ale_o    = ale_win[0];
          psen_no  = 1'b1;
          hi_sel_o = attr_i.wide_ptr;
        end else begin
          ale_o    = rfi_i ? 1'b1 : |ale_win;
          psen_no  = !(attr_i.ext_fetch && |psen_win);
          hi_sel_o = attr_i.ext_fetch;
        end
      end
    endcase
  end

endmodule

// File: rtl/ext_bus_strobe.sv
module ext_bus_strobe
  import ebs_pkg::*;
#(
  parameter int                CYC_LEN    = 12,
  parameter int                ALE_WIDTH  = 2,
  parameter int                PSEN_START = 3,
  parameter int                ADDR_W     = 8,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] RFI_ADDR   = 8'h8E,
  parameter int                RFI_BIT    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_fetch_i,
  input  logic              data_acc_i,
  input  logic              wide_ptr_i,
  input  logic              idle_i,
  input  logic              pdown_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic              ale_o,
  output logic              psen_no,
  output logic              hi_addr_sel_o
);

  localparam int PH_W = $clog2(CYC_LEN);

  pwr_mode_t       mode;
  cyc_attr_t       attr_in;
  cyc_attr_t       attr_q;
  logic [PH_W-1:0] phase_q;
  logic            rfi_q;

  assign mode = pdown_i ? PWR_DOWN : (idle_i ? PWR_IDLE : PWR_RUN);

  assign attr_in.ext_fetch = ext_fetch_i;
  assign attr_in.data_acc  = data_acc_i;
  assign attr_in.wide_ptr  = wide_ptr_i;

  ebs_phase_seq #(
    .CYC_LEN(CYC_LEN),
    .PH_W   (PH_W)
  ) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (mode != PWR_RUN),
    .attr_i (attr_in),
    .phase_o(phase_q),
    .attr_o (attr_q)
  );

  ebs_rfi_reg #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RFI_ADDR(RFI_ADDR),
    .RFI_BIT (RFI_BIT)
  ) i_rfi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .addr_i (cfg_addr_i),
    .wdata_i(cfg_wdata_i),
    .rfi_o  (rfi_q)
  );

  ebs_strobe_decode #(
    .CYC_LEN   (CYC_LEN),
    .PH_W      (PH_W),
    .ALE_WIDTH (ALE_WIDTH),
    .PSEN_START(PSEN_START)
  ) i_dec (
    .phase_i (phase_q),
    .attr_i  (attr_q),
    .rfi_i   (rfi_q),
    .mode_i  (mode),
    .ale_o   (ale_o),
    .psen_no (psen_no),
    .hi_sel_o(hi_addr_sel_o)
  );

endmodule

// File: rtl/ebs_chk.sv
module ebs_chk #(
  parameter int CYC_LEN = 12,
  parameter int PH_W    = $clog2(CYC_LEN)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            idle_i,
  input logic            pdown_i,
  input logic            cfg_we_i,
  input logic            ale_o,
  input logic            psen_no,
  input logic [PH_W-1:0] phase_q,
  input logic            rfi_q
);

  localparam logic [PH_W-1:0] PH_LIM = PH_W'(CYC_LEN - 1);

  // R13
  ale_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) && !cfg_we_i && !pdown_i |=> ale_o || pdown_i);

  // R13
  psen_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psen_no) && !pdown_i && !rfi_q && !$past(rfi_q) |-> $past(!ale_o));

  // R4
  psen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(psen_no) && !pdown_i |=> !psen_no || idle_i || pdown_i);

  // R12
  pdown_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_i |-> !ale_o && !psen_no);

  // R11
  idle_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i && !pdown_i |-> ale_o && psen_no);

  // R11
  lp_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(idle_i || pdown_i) |-> phase_q == '0);

  // R2
  phase_rng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= PH_LIM);

  // R10
  rfi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(rfi_q));

endmodule

bind ext_bus_strobe ebs_chk #(
  .CYC_LEN(CYC_LEN),
  .PH_W   (PH_W)
) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .idle_i  (idle_i),
  .pdown_i (pdown_i),
  .cfg_we_i(cfg_we_i),
  .ale_o   (ale_o),
  .psen_no (psen_no),
  .phase_q (phase_q),
  .rfi_q   (rfi_q)
);

// File: tb/test_ext_bus_strobe.sv
module test_ext_bus_strobe;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 6;

  // {ext, acc, wide}[27:25], ale per phase [24:13], psen_n per phase [12:1], hi [0]
  localparam logic [27:0] VEC [NVEC] = '{
    {3'b000, 12'h0C3, 12'hFFF, 1'b0},  // R2 internal fetch
    {3'b100, 12'h0C3, 12'h1C7, 1'b1},  // R4 external fetch
    {3'b111, 12'h003, 12'hFFF, 1'b1},  // R3 R5 R7 wide data access
    {3'b110, 12'h003, 12'hFFF, 1'b0},  // R3 R5 R7 narrow data access
    {3'b011, 12'h003, 12'hFFF, 1'b1},  // R3 R7 data access, internal fetch
    {3'b001, 12'h0C3, 12'hFFF, 1'b0}   // R7 wide ignored outside data access
  };

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       ext_fetch, data_acc, wide_ptr, idle, pdown, cfg_we;
  logic [7:0] cfg_addr, cfg_wdata;
  logic       ale, psen_n, hi_sel;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ext_bus_strobe i_ext_bus_strobe (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .ext_fetch_i  (ext_fetch),
    .data_acc_i   (data_acc),
    .wide_ptr_i   (wide_ptr),
    .idle_i       (idle),
    .pdown_i      (pdown),
    .cfg_we_i     (cfg_we),
    .cfg_addr_i   (cfg_addr),
    .cfg_wdata_i  (cfg_wdata),
    .ale_o        (ale),
    .psen_no      (psen_n),
    .hi_addr_sel_o(hi_sel)
  );

  task automatic chk(input string tag, input logic [2:0] exp);
    n_chk++;
    if ({ale, psen_n, hi_sel} !== exp) begin
      n_fail++;
      $display("FAIL %s: {ale,psen_n,hi} actual=%b expected=%b at %0t",
               tag, {ale, psen_n, hi_sel}, exp, $time);
    end
  endtask

  // One machine cycle from phase 0: attributes for the next cycle and an
  // optional config write are driven at phase 0; outputs checked per phase.
  task automatic run_cyc(input logic [11:0] ea, input logic [11:0] ep, input logic eh,
                         input logic [2:0] nxt, input logic wr, input logic [7:0] wa,
                         input logic [7:0] wd, input string tag);
    for (int ph = 0; ph < 12; ph++) begin
      if (ph == 0) begin
        {ext_fetch, data_acc, wide_ptr} = nxt;
        cfg_we = wr; cfg_addr = wa; cfg_wdata = wd;
      end else if (ph == 1) begin
        cfg_we = 1'b0;
      end
      #1;
      chk($sformatf("%s ph%0d", tag, ph), {ea[ph], ep[ph], eh});
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    {ext_fetch, data_acc, wide_ptr, idle, pdown, cfg_we} = '0;
    cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    #1 chk("R1 in reset", 3'b110);
    rst_ni = 1'b1;
    #1 chk("R1 after release", 3'b110);

    // first cycle runs with cleared attributes
    run_cyc(12'h0C3, 12'hFFF, 1'b0, VEC[0][27:25], 1'b0, 8'h0, 8'h0, "R1 R2 first cycle");

    // R6: each vector's attributes are driven one cycle ahead
    for (int i = 0; i < NVEC; i++) begin
      run_cyc(VEC[i][24:13], VEC[i][12:1], VEC[i][0],
              (i < NVEC - 1) ? VEC[i + 1][27:25] : 3'b000, 1'b0, 8'h0, 8'h0,
              $sformatf("R2 R3 R4 R5 R6 R7 vec%0d", i));
    end

    // R8 set noise-reduction bit: ALE parked high from phase 1
    run_cyc(12'hFFF, 12'hFFF, 1'b0, 3'b100, 1'b1, 8'h8E, 8'h01, "R8 set");
    // R8 psen unaffected; R9 write elsewhere ignored
    run_cyc(12'hFFF, 12'h1C7, 1'b1, 3'b111, 1'b1, 8'h8D, 8'h00, "R8 R9 other addr");
    // R8 data cycle keeps its pattern; clear with 0xFE (only bit 0 counts)
    run_cyc(12'h003, 12'hFFF, 1'b1, 3'b000, 1'b1, 8'h8E, 8'hFE, "R8 data cycle");
    run_cyc(12'h0C3, 12'hFFF, 1'b0, 3'b000, 1'b0, 8'h0, 8'h0, "R9 cleared by bit0");
    run_cyc(12'hFFF, 12'hFFF, 1'b0, 3'b000, 1'b1, 8'h8E, 8'h81, "R9 set upper bits");
    run_cyc(12'hFFF, 12'hFFF, 1'b0, 3'b000, 1'b0, 8'h0, 8'h0, "R10 bit kept");

    // R10 reset clears the bit
    rst_ni = 1'b0;
    #1 chk("R1 async reset", 3'b110);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    run_cyc(12'h0C3, 12'hFFF, 1'b0, 3'b000, 1'b0, 8'h0, 8'h0, "R10 reset clears");

    // R11 idle
    idle = 1'b1; ext_fetch = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R11 idle levels", 3'b110);
      @(negedge clk);
    end
    // R12 power down, with and without idle
    pdown = 1'b1;
    #1 chk("R12 pdown over idle", 3'b000);
    @(negedge clk);
    idle = 1'b0;
    #1 chk("R12 pdown", 3'b000);
    @(negedge clk);
    #1 chk("R12 pdown held", 3'b000);
    @(negedge clk);
    pdown = 1'b0;
    run_cyc(12'h0C3, 12'h1C7, 1'b1, 3'b000, 1'b0, 8'h0, 8'h0, "R11 restart at phase 0");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule